// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block sits between a register port and a three-wire serial configuration EEPROM of 512 bytes. Software writes an opcode and a byte address into a command register with the busy bit set. The controller then clocks the matching serial frame out to the EEPROM, collects a returned byte or sends the byte held in the data register, and waits for the device to finish programming. After that it drops busy. Eight opcodes are supported: byte read, byte write, byte erase, fill all, erase all, arming and disarming of programming, and a reload that reads the header byte and reports whether it holds the expected signature.

A fixed cycle budget bounds every command. If the EEPROM never reports that programming has completed, the controller gives up, releases the serial lines, clears busy and sets a timeout flag. Programming commands are also checked against a write-enable state that the controller keeps itself. A program command issued while disarmed completes at once and sends nothing to the device.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, busy, timeout, loaded, the opcode and address fields and the data register all read zero, and chip select and serial clock are low.
- R2: The command register (select 0) reads busy at bit 31, the opcode at bits 30:28, timeout at bit 10, loaded at bit 9 and the byte address at bits 8:0, with all other bits zero. Opcode and address are those of the last accepted command. The data register (select 1) holds its byte in bits 7:0.
- R3: Opcode 0 (read) loads the EEPROM byte at the given address into the data register before busy clears.
- R4: Opcode 3 (write) stores the data register byte at the address, and opcode 5 (erase) sets that byte to 0xFF. Both act only while programming is armed.
- R5: Opcode 4 (write-all) stores the data register byte at every address, and opcode 6 (erase-all) sets every byte to 0xFF. Both act only while programming is armed.
- R6: Programming is disarmed after reset and by opcode 1, and is armed by opcode 2. While it is disarmed, opcodes 3 to 6 complete with the timeout flag clear and leave the EEPROM unchanged.
- R7: Opcode 7 (reload) reads address 0 and sets loaded to 1 if the byte equals LOAD_MAGIC (0xA5), or to 0 otherwise. It leaves the data register unchanged.
- R8: If a command is still running after TIMEOUT_CYCLES cycles, busy clears, timeout is set and chip select drops. Accepting the next command clears timeout.
- R9: A write to either register while busy reads 1 has no effect. A command starts only on a command-register write with bit 31 set.
- R10: Each frame is sent MSB first while chip select is high, and the EEPROM samples on the serial clock rising edge. The frame is a start bit of 1, then a two-bit code (10 read, 01 write, 11 erase, 00 special), then nine address bits, then eight data bits for writes. The special frames carry 11, 00, 01 or 10 in the top two address bits for arm, disarm, write-all and erase-all. The serial clock is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The command sequencer finishing and a new host write can land on the same clock edge. The write must be dropped, because busy still reads high at that edge, and the next write after busy reads low must be accepted. The bench provokes this by writing the command and data registers on every cycle while a read is in flight, so the last of those writes hits the completion edge. Afterwards the bench checks that the opcode, address and returned byte belong to the original command. The watchdog expiring while the device is still busy is provoked by a model EEPROM that never signals ready. The bench then checks that busy, timeout and chip select all settle together.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

    localparam int ADDR_W    = 9;
    localparam int DATA_W    = 8;
    localparam int HDR_W     = 1 + 2 + ADDR_W;
    localparam int FRAME_W   = HDR_W + DATA_W;
    localparam int BITCNT_W  = $clog2(FRAME_W + 1);

    localparam int BIT_BUSY   = 31;
    localparam int OPC_LSB    = 28;
    localparam int BIT_TOUT   = 10;
    localparam int BIT_LOADED = 9;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WDIS   = 3'd1,
        OP_WEN    = 3'd2,
        OP_WRITE  = 3'd3,
        OP_WRALL  = 3'd4,
        OP_ERASE  = 3'd5,
        OP_ERALL  = 3'd6,
        OP_RELOAD = 3'd7
    } ee_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LEAD, S_SHIFT, S_GAP, S_POLL, S_FIN
    } seq_st_e;

    typedef struct packed {
        ee_op_e              op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                skip;
    } ee_job_t;

    function automatic logic is_program(ee_op_e op);
        return (op == OP_WRITE) || (op == OP_WRALL) ||
               (op == OP_ERASE) || (op == OP_ERALL);
    endfunction

    function automatic logic reads_byte(ee_op_e op);
        return (op == OP_READ) || (op == OP_RELOAD);
    endfunction

    function automatic logic carries_data(ee_op_e op);
        return (op == OP_WRITE) || (op == OP_WRALL);
    endfunction

    function automatic logic [BITCNT_W-1:0] frame_len(ee_op_e op);
        if (reads_byte(op) || carries_data(op))
            return BITCNT_W'(FRAME_W);
        return BITCNT_W'(HDR_W);
    endfunction

    // Left-justified serial frame: start, two-bit code, address, data.
    function automatic logic [FRAME_W-1:0] build_frame(ee_op_e op,
                                                       logic [ADDR_W-1:0] addr,
                                                       logic [DATA_W-1:0] data);
        logic [FRAME_W-1:0] f;
        case (op)
            OP_READ:   f = {1'b1, 2'b10, addr, {DATA_W{1'b0}}};
            OP_RELOAD: f = {1'b1, 2'b10, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
            OP_WRITE:  f = {1'b1, 2'b01, addr, data};
            OP_ERASE:  f = {1'b1, 2'b11, addr, {DATA_W{1'b0}}};
            OP_WEN:    f = {1'b1, 2'b00, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
            OP_WDIS:   f = {1'b1, 2'b00, 2'b00, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
            OP_WRALL:  f = {1'b1, 2'b00, 2'b01, {(ADDR_W-2){1'b0}}, data};
            default:   f = {1'b1, 2'b00, 2'b10, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/eeprom_cmd_tick.sv
module eeprom_cmd_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/eeprom_cmd_regs.sv
module eeprom_cmd_regs
    import eeprom_cmd_pkg::*;
#(
    parameter logic [7:0] LOAD_MAGIC = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 job_start,
    output ee_job_t              job,
    input  logic                 done,
    input  logic                 done_tout,
    input  logic [DATA_W-1:0]    rx_byte,
    output logic                 busy,
    output logic                 tout,
    output logic [DATA_W-1:0]    data_reg
);
    logic                 busy_q;
    ee_op_e               op_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    data_q;
    logic                 tout_q;
    logic                 loaded_q;
    logic                 wen_q;

    ee_op_e new_op;
    logic   accept;
    logic   data_wr;
    logic   unused_wbits;

    assign new_op    = ee_op_e'(reg_wdata[OPC_LSB +: 3]);
    assign accept    = reg_wr && !reg_sel && reg_wdata[BIT_BUSY] && !busy_q;
    assign data_wr   = reg_wr && reg_sel && !busy_q;
    assign unused_wbits = ^reg_wdata[OPC_LSB-1:ADDR_W];

    assign job_start = accept;
    assign job.op    = new_op;
    assign job.addr  = reg_wdata[ADDR_W-1:0];
    assign job.data  = data_q;
    assign job.skip  = is_program(new_op) && !wen_q;

    always_comb begin
        if (reg_sel)
            reg_rdata = {{(32-DATA_W){1'b0}}, data_q};
        else
            reg_rdata = {busy_q, op_q, {(BIT_TOUT-1-ADDR_W-1+1+(OPC_LSB-BIT_TOUT-1)-(BIT_TOUT-1-ADDR_W-1+1)){1'b0}},
                         tout_q, loaded_q, addr_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            op_q     <= OP_READ;
            addr_q   <= '0;
            data_q   <= '0;
            tout_q   <= 1'b0;
            loaded_q <= 1'b0;
            wen_q    <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            op_q   <= new_op;
            addr_q <= reg_wdata[ADDR_W-1:0];
            tout_q <= 1'b0;
            if (new_op == OP_WEN)
                wen_q <= 1'b1;
            else if (new_op == OP_WDIS)
                wen_q <= 1'b0;
        end else if (data_wr) begin
            data_q <= reg_wdata[DATA_W-1:0];
        end else if (busy_q && done) begin
            busy_q <= 1'b0;
            tout_q <= done_tout;
            if (op_q == OP_RELOAD)
                loaded_q <= !done_tout && (rx_byte == LOAD_MAGIC);
            else if (op_q == OP_READ && !done_tout)
                data_q <= rx_byte;
        end
    end

    assign busy     = busy_q;
    assign tout     = tout_q;
    assign data_reg = data_q;
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
    import eeprom_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 20000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  ee_job_t              job,
    input  logic                 tick,
    output logic                 run,
    input  logic                 ee_do,
    output logic                 ee_cs,
    output logic                 ee_sck,
    output logic                 ee_di,
    output logic                 done,
    output logic                 done_tout,
    output logic [DATA_W-1:0]    rx_byte
);
    localparam int WD_W = $clog2(TIMEOUT_CYCLES + 1);

    seq_st_e               st_q;
    logic [FRAME_W-1:0]    frame_q;
    logic [BITCNT_W-1:0]   idx_q;
    logic [BITCNT_W-1:0]   len_q;
    logic                  rd_q;
    logic                  poll_q;
    logic                  half_q;
    logic                  cs_q;
    logic                  sck_q;
    logic                  di_q;
    logic [DATA_W-1:0]     rx_q;
    logic [WD_W-1:0]       wd_q;
    logic                  tout_q;
    logic                  active;

    assign active = (st_q == S_LEAD) || (st_q == S_SHIFT) ||
                    (st_q == S_GAP)  || (st_q == S_POLL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            frame_q <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            rd_q    <= 1'b0;
            poll_q  <= 1'b0;
            half_q  <= 1'b0;
            cs_q    <= 1'b0;
            sck_q   <= 1'b0;
            di_q    <= 1'b0;
            rx_q    <= '0;
            wd_q    <= '0;
            tout_q  <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        tout_q <= 1'b0;
                        wd_q   <= '0;
                        if (job.skip) begin
                            st_q <= S_FIN;
                        end else begin
                            frame_q <= build_frame(job.op, job.addr, job.data);
                            len_q   <= frame_len(job.op);
                            rd_q    <= reads_byte(job.op);
                            poll_q  <= is_program(job.op);
                            idx_q   <= '0;
                            half_q  <= 1'b0;
                            cs_q    <= 1'b1;
                            st_q    <= S_LEAD;
                        end
                    end
                end
                S_LEAD: begin
                    if (tick) begin
                        di_q <= frame_q[FRAME_W-1];
                        st_q <= S_SHIFT;
                    end
                end
                S_SHIFT: begin
                    if (tick) begin
                        if (!half_q) begin
                            sck_q  <= 1'b1;
                            half_q <= 1'b1;
                        end else begin
                            sck_q  <= 1'b0;
                            half_q <= 1'b0;
                            if (rd_q && idx_q >= BITCNT_W'(HDR_W))
                                rx_q <= {rx_q[DATA_W-2:0], ee_do};
                            if (idx_q == len_q - 1'b1) begin
                                di_q <= 1'b0;
                                cs_q <= 1'b0;
                                st_q <= poll_q ? S_GAP : S_FIN;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                                di_q    <= frame_q[FRAME_W-2];
                            end
                        end
                    end
                end
                S_GAP: begin
                    if (tick) begin
                        cs_q <= 1'b1;
                        st_q <= S_POLL;
                    end
                end
                S_POLL: begin
                    if (ee_do) begin
                        cs_q <= 1'b0;
                        st_q <= S_FIN;
                    end
                end
                default: st_q <= S_IDLE;
            endcase

            // Watchdog: overrides whatever the state machine chose this cycle.
            if (active) begin
                if (wd_q == WD_W'(TIMEOUT_CYCLES - 1)) begin
                    st_q   <= S_FIN;
                    cs_q   <= 1'b0;
                    sck_q  <= 1'b0;
                    di_q   <= 1'b0;
                    half_q <= 1'b0;
                    tout_q <= 1'b1;
                end else begin
                    wd_q <= wd_q + 1'b1;
                end
            end
        end
    end

    assign run       = active;
    assign done      = (st_q == S_FIN);
    assign done_tout = tout_q;
    assign rx_byte   = rx_q;
    assign ee_cs     = cs_q;
    assign ee_sck    = sck_q;
    assign ee_di     = di_q;
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
    import eeprom_cmd_pkg::*;
#(
    parameter int         CLK_DIV        = 4,
    parameter int         TIMEOUT_CYCLES = 20000,
    parameter logic [7:0] LOAD_MAGIC     = 8'hA5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        ee_cs,
    output logic        ee_sck,
    output logic        ee_di,
    input  logic        ee_do
);
    ee_job_t             job_w;
    logic                start_w;
    logic                done_w;
    logic                done_tout_w;
    logic [DATA_W-1:0]   rx_w;
    logic                busy_w;
    logic                tout_w;
    logic [DATA_W-1:0]   data_w;
    logic                tick_w;
    logic                run_w;

    eeprom_cmd_regs #(.LOAD_MAGIC(LOAD_MAGIC)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .job_start (start_w),
        .job       (job_w),
        .done      (done_w),
        .done_tout (done_tout_w),
        .rx_byte   (rx_w),
        .busy      (busy_w),
        .tout      (tout_w),
        .data_reg  (data_w)
    );

    eeprom_cmd_tick #(.CLK_DIV(CLK_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .run  (run_w),
        .tick (tick_w)
    );

    eeprom_cmd_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .job       (job_w),
        .tick      (tick_w),
        .run       (run_w),
        .ee_do     (ee_do),
        .ee_cs     (ee_cs),
        .ee_sck    (ee_sck),
        .ee_di     (ee_di),
        .done      (done_w),
        .done_tout (done_tout_w),
        .rx_byte   (rx_w)
    );
endmodule

// File: rtl/eeprom_cmd_ctrl_chk.sv
module eeprom_cmd_ctrl_chk #(
    parameter int TIMEOUT_CYCLES = 20000
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       tout,
    input logic [7:0] data_reg,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic       wr_busy_bit,
    input logic       ee_cs,
    input logic       ee_sck
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_run <= 0;
        else
            busy_run <= busy_run + 1;
    end

    p_sck_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
        ee_sck |-> ee_cs);

    p_idle_cs_low_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ee_cs);

    p_start_by_write_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr && !reg_sel && wr_busy_bit));

    p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(data_reg));

    p_tout_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tout) |-> $fell(busy));

    p_busy_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        busy_run <= TIMEOUT_CYCLES + 4);
endmodule

bind eeprom_cmd_ctrl eeprom_cmd_ctrl_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy_w),
    .tout        (tout_w),
    .data_reg    (data_w),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .wr_busy_bit (reg_wdata[31]),
    .ee_cs       (ee_cs),
    .ee_sck      (ee_sck)
);

// File: tb/eeprom_cmd_ctrl_tb_top.sv
module eeprom_cmd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int TMO        = 400;
    localparam int PROG_TIME  = 100;
    localparam logic [7:0] MAGIC = 8'hA5;

    localparam logic [2:0] C_READ = 3'd0, C_WDIS = 3'd1, C_WEN = 3'd2, C_WRITE = 3'd3,
                           C_WRALL = 3'd4, C_ERASE = 3'd5, C_ERALL = 3'd6, C_RELOAD = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_cs, ee_sck, ee_di, ee_do;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_cmd_ctrl #(.CLK_DIV(DIV), .TIMEOUT_CYCLES(TMO), .LOAD_MAGIC(MAGIC)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- behavioural serial EEPROM ----------------
    logic [7:0]  ee_mem [512];
    logic        m_wen = 1'b0;
    int          m_bits = 0;
    logic [19:0] m_sh = '0;
    logic        m_out_en = 1'b0;
    logic [7:0]  m_out = '0;
    logic        m_dbit = 1'b0;
    int          m_prog = 0;
    bit          m_dead = 1'b0;
    int          bad_frames = 0;
    logic        sck_prev = 1'b0;
    logic        cs_prev = 1'b0;

    assign ee_do = m_out_en ? m_dbit : (ee_cs && m_bits == 0 && m_prog == 0 && !m_dead);

    always @(negedge clk) begin
        if (m_prog > 0) m_prog = m_prog - 1;
        if (ee_sck && !sck_prev) begin
            m_bits = m_bits + 1;
            m_sh = {m_sh[18:0], ee_di};
            if (m_bits == 12) begin
                if (m_sh[11] !== 1'b1) bad_frames++;
                if (m_sh[10:9] == 2'b10) begin
                    m_out = ee_mem[m_sh[8:0]];
                    m_out_en = 1'b1;
                    m_dbit = 1'b0;
                end else if (m_sh[10:9] == 2'b00) begin
                    if (m_sh[8:7] == 2'b11) m_wen = 1'b1;
                    else if (m_sh[8:7] == 2'b00) m_wen = 1'b0;
                end
            end else if (m_bits > 12 && m_out_en) begin
                m_dbit = m_out[7];
                m_out = {m_out[6:0], 1'b0};
            end
        end
        if (cs_prev && !ee_cs) begin
            if (m_wen && m_bits == 20 && m_sh[18:17] == 2'b01) begin
                ee_mem[m_sh[16:8]] = m_sh[7:0];
                m_prog = PROG_TIME;
            end else if (m_wen && m_bits == 20 && m_sh[18:17] == 2'b00 && m_sh[16:15] == 2'b01) begin
                for (int i = 0; i < 512; i++) ee_mem[i] = m_sh[7:0];
                m_prog = PROG_TIME;
            end else if (m_wen && m_bits == 12 && m_sh[10:9] == 2'b11) begin
                ee_mem[m_sh[8:0]] = 8'hFF;
                m_prog = PROG_TIME;
            end else if (m_wen && m_bits == 12 && m_sh[10:9] == 2'b00 && m_sh[8:7] == 2'b10) begin
                for (int i = 0; i < 512; i++) ee_mem[i] = 8'hFF;
                m_prog = PROG_TIME;
            end
            if (m_bits != 0 && m_bits != 12 && m_bits != 20) bad_frames++;
            m_bits = 0;
            m_out_en = 1'b0;
        end
        sck_prev = ee_sck;
        cs_prev = ee_cs;
    end

    // ---------------- reference model ----------------
    logic [7:0] ref_mem [512];
    bit         ref_wen = 1'b0;
    logic [7:0] exp_data = '0;
    bit         exp_loaded = 1'b0;
    bit         exp_to = 1'b0;
    logic [2:0] exp_op = '0;
    logic [8:0] exp_addr = '0;
    bit         armed = 1'b0;

    function automatic logic [31:0] exp_cmd_word();
        return {1'b0, exp_op, 17'd0, exp_to, exp_loaded, exp_addr};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Compared every clock while the controller is idle.
    always begin
        @(negedge clk);
        #3;
        if (armed && !rst) begin
            if (reg_sel)
                check(reg_rdata === {24'd0, exp_data}, "R2 idle data", reg_rdata, {24'd0, exp_data});
            else
                check(reg_rdata === exp_cmd_word(), "R2 idle cmd", reg_rdata, exp_cmd_word());
            check({ee_cs, ee_sck} === 2'b00, "R10 idle lines", {30'd0, ee_cs, ee_sck}, 32'd0);
        end
    end

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [8:0] addr, input logic [7:0] wdat,
                           input bit hammer, input bit expect_to, input string tag);
        int guard;
        armed = 1'b0;
        write_reg(1'b1, {24'd0, wdat});
        write_reg(1'b0, {1'b1, op, 19'd0, addr});
        exp_op = op; exp_addr = addr; exp_to = expect_to; exp_data = wdat;
        case (op)
            C_READ:   exp_data = ref_mem[addr];
            C_WDIS:   ref_wen = 1'b0;
            C_WEN:    ref_wen = 1'b1;
            C_WRITE:  if (ref_wen) ref_mem[addr] = wdat;
            C_ERASE:  if (ref_wen) ref_mem[addr] = 8'hFF;
            C_WRALL:  if (ref_wen) for (int i = 0; i < 512; i++) ref_mem[i] = wdat;
            C_ERALL:  if (ref_wen) for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
            default:  exp_loaded = !expect_to && (ref_mem[0] == MAGIC);
        endcase
        guard = 0;
        forever begin
            @(negedge clk);
            reg_wr = 1'b0; reg_sel = 1'b0;
            #1;
            if (!reg_rdata[31]) break;
            guard++;
            if (guard > 5000) begin
                check(1'b0, {tag, " busy stuck"}, reg_rdata, 32'd0);
                break;
            end
            if (hammer) begin
                reg_wr = 1'b1;
                if (guard % 2 == 1) begin
                    reg_sel = 1'b0;
                    reg_wdata = {1'b1, C_ERALL, 19'd0, addr ^ 9'h0AA};
                end else begin
                    reg_sel = 1'b1;
                    reg_wdata = 32'h0000_00C3;
                end
            end
        end
        reg_wr = 1'b0;
        #1;
        check(reg_rdata === exp_cmd_word(), {tag, " cmd"}, reg_rdata, exp_cmd_word());
        reg_sel = 1'b1;
        #1;
        check(reg_rdata === {24'd0, exp_data}, {tag, " data"}, reg_rdata, {24'd0, exp_data});
        reg_sel = 1'b0;
        armed = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            ee_mem[i]  = 8'(i) ^ 8'h96;
            ref_mem[i] = 8'(i) ^ 8'h96;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        check(reg_rdata === 32'd0, "R1 cmd after reset", reg_rdata, 32'd0);
        reg_sel = 1'b1; #1;
        check(reg_rdata === 32'd0, "R1 data after reset", reg_rdata, 32'd0);
        reg_sel = 1'b0;
        check({ee_cs, ee_sck} === 2'b00, "R1 lines after reset", {30'd0, ee_cs, ee_sck}, 32'd0);
        armed = 1'b1;

        // R3 reads, with R2 field readback
        run_cmd(C_READ, 9'd5, 8'h00, 1'b0, 1'b0, "R3 read 5");
        run_cmd(C_READ, 9'h1FF, 8'h11, 1'b0, 1'b0, "R3 read top");
        // R6 disarmed after reset
        run_cmd(C_WRITE, 9'd5, 8'h3C, 1'b0, 1'b0, "R6 write disarmed");
        run_cmd(C_READ, 9'd5, 8'h00, 1'b0, 1'b0, "R6 readback");
        // R4 write and erase
        run_cmd(C_WEN, 9'd0, 8'h00, 1'b0, 1'b0, "R6 arm");
        run_cmd(C_WRITE, 9'd5, 8'h3C, 1'b0, 1'b0, "R4 write");
        run_cmd(C_READ, 9'd5, 8'h00, 1'b0, 1'b0, "R4 readback write");
        run_cmd(C_ERASE, 9'd6, 8'h00, 1'b0, 1'b0, "R4 erase");
        run_cmd(C_READ, 9'd6, 8'h00, 1'b0, 1'b0, "R4 readback erase");
        // R7 reload
        run_cmd(C_RELOAD, 9'd0, 8'h44, 1'b0, 1'b0, "R7 reload no magic");
        run_cmd(C_WRITE, 9'd0, MAGIC, 1'b0, 1'b0, "R4 write magic");
        run_cmd(C_RELOAD, 9'd0, 8'h45, 1'b0, 1'b0, "R7 reload magic");
        // R5 write-all
        run_cmd(C_WRALL, 9'd0, 8'h5A, 1'b0, 1'b0, "R5 write all");
        run_cmd(C_READ, 9'd0, 8'h00, 1'b0, 1'b0, "R5 read 0");
        run_cmd(C_READ, 9'h100, 8'h00, 1'b0, 1'b0, "R5 read 256");
        run_cmd(C_READ, 9'h1FF, 8'h00, 1'b0, 1'b0, "R5 read 511");
        // R6 disarm then erase-all ignored
        run_cmd(C_WDIS, 9'd0, 8'h00, 1'b0, 1'b0, "R6 disarm");
        run_cmd(C_ERALL, 9'd0, 8'h00, 1'b0, 1'b0, "R6 erase all disarmed");
        run_cmd(C_READ, 9'd3, 8'h00, 1'b0, 1'b0, "R6 read after blocked erase");
        // R5 erase-all armed
        run_cmd(C_WEN, 9'd0, 8'h00, 1'b0, 1'b0, "R6 rearm");
        run_cmd(C_ERALL, 9'd0, 8'h00, 1'b0, 1'b0, "R5 erase all");
        run_cmd(C_READ, 9'd7, 8'h00, 1'b0, 1'b0, "R5 read after erase all");
        // R9 writes while busy are dropped
        run_cmd(C_WRITE, 9'd10, 8'h77, 1'b0, 1'b0, "R4 write 10");
        run_cmd(C_READ, 9'd10, 8'h00, 1'b1, 1'b0, "R9 hammered read");
        run_cmd(C_READ, 9'd11, 8'h00, 1'b0, 1'b0, "R9 accepted after busy");
        // R8 timeout with a silent EEPROM
        m_dead = 1'b1;
        run_cmd(C_WRITE, 9'd2, 8'h9D, 1'b0, 1'b1, "R8 timeout");
        check(ee_cs === 1'b0, "R8 cs released", {31'd0, ee_cs}, 32'd0);
        m_dead = 1'b0;
        run_cmd(C_READ, 9'd2, 8'h00, 1'b0, 1'b0, "R8 timeout cleared");
        // R10 framing seen by the EEPROM model
        check(bad_frames == 0, "R10 frame shape", 32'(bad_frames), 32'd0);
        repeat (5) @(negedge clk);
        armed = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule